// File: doc/BRIEF.md
# Packed Saturating Byte/Word ALU

This unit performs five packed operations on a 64-bit datapath. Three finish in one cycle: signed-word saturating add, signed-word saturating subtract and unsigned byte averaging. Two finish in two cycles: a byte absolute-difference that accumulates into an existing value with unsigned saturation, and a per-word selection of the operand with the larger magnitude. The surrounding pipeline supplies three values. `opnd_reg` is the register operand, `opnd_src` is the source operand from a register or memory, and `partner_val` is the current content of the partner register.

Some results go to the named destination and some go to its partner register. The partner index is the named index with its least significant bit flipped. The unit reports the index to write and a flag that says which kind of register it is, together with a one-cycle `done` pulse. While a two-cycle operation is in flight, a new `start` is dropped.

Top module: `pk_satalu`

## Requirements
- R1: After reset, `done`, `res`, `wr_partner` and `wr_idx` are all zero.
- R2: Opcode 0 adds the four signed 16-bit words of `opnd_reg` and `opnd_src` and clamps each sum to the range -32768..32767. The result goes to the partner register, and `done` is high in the cycle after the start edge.
- R3: Opcode 1 computes `opnd_reg` minus `opnd_src` per signed word, clamps each word as in R2, writes the partner register, and has a latency of 1 cycle.
- R4: Opcode 2 computes (a + b + 1) >> 1 for each of the eight unsigned byte pairs of `opnd_reg` and `opnd_src`. It writes the named register and has a latency of 1 cycle.
- R5: Opcode 3 adds |a - b| of each unsigned byte pair to the matching byte of `partner_val` and clamps the sum at 255. It writes the partner register, `done` stays low in the first cycle after the start edge, and `done` rises in the second.
- R6: Opcode 4 gives, per 16-bit word, the input word with the larger absolute value. When the magnitudes are equal it keeps the `opnd_reg` word, and -32768 counts as magnitude 32768. It writes the named register and has a latency of 2 cycles.
- R7: When `wr_partner` is 1, `wr_idx` is `dst_idx` with bit 0 inverted. When `wr_partner` is 0, `wr_idx` equals `dst_idx`.
- R8: Each accepted start produces exactly one `done` pulse, one cycle wide. A start in the cycle after a two-cycle operation is accepted is ignored.
- R9: Opcodes 5 to 7 are ignored. They produce no `done`, and `res` keeps its value.
- R10: `res`, `wr_idx` and `wr_partner` hold their values until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation this cycle |
| op | input | 3 | Operation select (0 add, 1 sub, 2 avg, 3 dist-acc, 4 magnitude) |
| dst_idx | input | 3 | Named destination register index |
| opnd_reg | input | 64 | Register operand |
| opnd_src | input | 64 | Source operand (register or memory) |
| partner_val | input | 64 | Current partner-register content |
| res | output | 64 | Result of the last completed operation |
| wr_idx | output | 3 | Register index to write |
| wr_partner | output | 1 | 1 when the result targets the partner register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a start that arrives while a two-cycle operation is still in flight. The stimulus gets there by holding `start` high for one more cycle after a distance-accumulate is accepted, with a different opcode and different operands. The bench then checks that only the first operation's result and a single `done` pulse appear. The saturation corners are reached by sweeping every pair from a set of word values that includes both extremes and -32768, and by sweeping byte grids whose partner bytes come close to 255.

// File: rtl/pk_satalu_pkg.sv
package pk_satalu_pkg;
   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      OP_ADDS = 3'd0,
      OP_SUBS = 3'd1,
      OP_AVGB = 3'd2,
      OP_DACC = 3'd3,
      OP_MAGW = 3'd4
   } op_e;

   function automatic logic op_valid(input logic [2:0] o);
      return o <= 3'd4;
   endfunction

   function automatic logic op_two_cycle(input logic [2:0] o);
      return (o == OP_DACC) || (o == OP_MAGW);
   endfunction

   function automatic logic op_to_partner(input logic [2:0] o);
      return (o == OP_ADDS) || (o == OP_SUBS) || (o == OP_DACC);
   endfunction

   // magnitude of a signed word, 17 bits so that -32768 maps to 32768
   function automatic logic [WORD_W:0] word_mag(input logic [WORD_W-1:0] w);
      logic [WORD_W:0] ext;
      ext = {w[WORD_W-1], w};
      return w[WORD_W-1] ? (~ext + 1'b1) : ext;
   endfunction
endpackage

// File: rtl/pk_word_lanes.sv
module pk_word_lanes
   import pk_satalu_pkg::*;
#(
   parameter int NWORDS = 4
) (
   input  logic                     do_sub,
   input  logic [NWORDS*WORD_W-1:0] a,
   input  logic [NWORDS*WORD_W-1:0] b,
   output logic [NWORDS*WORD_W-1:0] sat_out,
   output logic [NWORDS-1:0]        b_bigger
);
   localparam logic signed [WORD_W:0] MAXV = 17'sd32767;
   localparam logic signed [WORD_W:0] MINV = -17'sd32768;

   initial begin
      if (NWORDS < 1) $error("pk_word_lanes: NWORDS must be at least 1");
   end

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic signed [WORD_W:0] xa, xb, s;
      always_comb begin
         xa = {a[w*WORD_W+WORD_W-1], a[w*WORD_W +: WORD_W]};
         xb = {b[w*WORD_W+WORD_W-1], b[w*WORD_W +: WORD_W]};
         s  = do_sub ? (xa - xb) : (xa + xb);
         if (s > MAXV)      sat_out[w*WORD_W +: WORD_W] = 16'h7FFF;
         else if (s < MINV) sat_out[w*WORD_W +: WORD_W] = 16'h8000;
         else               sat_out[w*WORD_W +: WORD_W] = s[WORD_W-1:0];
         b_bigger[w] = word_mag(b[w*WORD_W +: WORD_W]) > word_mag(a[w*WORD_W +: WORD_W]);
      end

      // R2: two non-negative words never add to a negative result
      always_comb begin
         if (!do_sub && !a[w*WORD_W+WORD_W-1] && !b[w*WORD_W+WORD_W-1])
            a_r2_pos_sum_nonneg: assert (!sat_out[w*WORD_W+WORD_W-1]);
      end
   end
endmodule

// File: rtl/pk_byte_lanes.sv
module pk_byte_lanes
   import pk_satalu_pkg::*;
#(
   parameter int NBYTES = 8
) (
   input  logic [NBYTES*BYTE_W-1:0] a,
   input  logic [NBYTES*BYTE_W-1:0] b,
   input  logic [NBYTES*BYTE_W-1:0] acc_d,
   input  logic [NBYTES*BYTE_W-1:0] acc_base,
   output logic [NBYTES*BYTE_W-1:0] avg_out,
   output logic [NBYTES*BYTE_W-1:0] dist_out,
   output logic [NBYTES*BYTE_W-1:0] acc_out
);
   initial begin
      if (NBYTES < 1) $error("pk_byte_lanes: NBYTES must be at least 1");
   end

   for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      logic [BYTE_W-1:0] ua, ub, ud, ubase;
      logic [BYTE_W:0]   avg_sum, acc_sum;
      always_comb begin
         ua      = a[k*BYTE_W +: BYTE_W];
         ub      = b[k*BYTE_W +: BYTE_W];
         ud      = acc_d[k*BYTE_W +: BYTE_W];
         ubase   = acc_base[k*BYTE_W +: BYTE_W];
         avg_sum = {1'b0, ua} + {1'b0, ub} + 9'd1;
         avg_out[k*BYTE_W +: BYTE_W]  = avg_sum[BYTE_W:1];
         dist_out[k*BYTE_W +: BYTE_W] = (ua > ub) ? (ua - ub) : (ub - ua);
         acc_sum = {1'b0, ud} + {1'b0, ubase};
         acc_out[k*BYTE_W +: BYTE_W]  = acc_sum[BYTE_W] ? {BYTE_W{1'b1}} : acc_sum[BYTE_W-1:0];
      end

      // R4: the rounded mean lies between the two inputs
      always_comb begin
         a_r4_avg_between: assert (avg_out[k*BYTE_W +: BYTE_W] >= ((ua < ub) ? ua : ub) &&
                                   avg_out[k*BYTE_W +: BYTE_W] <= ((ua > ub) ? ua : ub));
      end
      // R5: accumulation never drops below the base byte
      always_comb begin
         a_r5_acc_no_wrap: assert (acc_out[k*BYTE_W +: BYTE_W] >= ubase);
      end
   end
endmodule

// File: rtl/pk_seq.sv
module pk_seq
   import pk_satalu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [2:0] op,
   output logic       take1,
   output logic       take2,
   output logic       busy,
   output logic       done
);
   logic ok;
   always_comb begin
      ok    = start && !busy && op_valid(op);
      take1 = ok && !op_two_cycle(op);
      take2 = ok && op_two_cycle(op);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         busy <= take2;
         done <= take1 || busy;
      end
   end

   a_r8_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);
   a_r8_busy_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> done);
   a_r5_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
      take2 |=> !done);
   a_r9_bad_op_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !op_valid(op)) |=> !done);
endmodule

// File: rtl/pk_satalu.sv
module pk_satalu
   import pk_satalu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic [DATA_W-1:0] opnd_reg,
   input  logic [DATA_W-1:0] opnd_src,
   input  logic [DATA_W-1:0] partner_val,
   output logic [DATA_W-1:0] res,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              wr_partner,
   output logic              done
);
   localparam int NWORDS = DATA_W / WORD_W;
   localparam int NBYTES = DATA_W / BYTE_W;
   localparam logic [IDX_W-1:0] FLIP = {{(IDX_W-1){1'b0}}, 1'b1};

   initial begin
      if (DATA_W % WORD_W != 0) $error("pk_satalu: DATA_W must be a multiple of 16");
      if (IDX_W < 1)            $error("pk_satalu: IDX_W must be at least 1");
   end

   logic take1, take2, busy;
   logic [DATA_W-1:0] sat_w, avg_b, dist_b, acc_b, fin;
   logic [NWORDS-1:0] bigger;

   // stage-one state for the two-cycle operations
   logic [DATA_W-1:0] s1_x, s1_y;
   logic [NWORDS-1:0] s1_sel;
   logic              s1_dacc;
   logic [IDX_W-1:0]  s1_dst;

   pk_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .take1(take1), .take2(take2), .busy(busy), .done(done)
   );

   pk_word_lanes #(.NWORDS(NWORDS)) u_words (
      .do_sub(op == OP_SUBS), .a(opnd_reg), .b(opnd_src),
      .sat_out(sat_w), .b_bigger(bigger)
   );

   pk_byte_lanes #(.NBYTES(NBYTES)) u_bytes (
      .a(opnd_reg), .b(opnd_src), .acc_d(s1_x), .acc_base(s1_y),
      .avg_out(avg_b), .dist_out(dist_b), .acc_out(acc_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_x    <= '0;
         s1_y    <= '0;
         s1_sel  <= '0;
         s1_dacc <= 1'b0;
         s1_dst  <= '0;
      end else if (take2) begin
         s1_dacc <= (op == OP_DACC);
         s1_x    <= (op == OP_DACC) ? dist_b : opnd_reg;
         s1_y    <= (op == OP_DACC) ? partner_val : opnd_src;
         s1_sel  <= bigger;
         s1_dst  <= dst_idx;
      end
   end

   // second stage: pick accumulate result or per-word winner
   for (genvar w = 0; w < NWORDS; w++) begin : g_pick
      always_comb begin
         if (s1_dacc)
            fin[w*WORD_W +: WORD_W] = acc_b[w*WORD_W +: WORD_W];
         else
            fin[w*WORD_W +: WORD_W] = s1_sel[w] ? s1_y[w*WORD_W +: WORD_W]
                                                : s1_x[w*WORD_W +: WORD_W];
      end
      // R6: the chosen word is never smaller in magnitude than the other one
      always_comb begin
         if (busy && !s1_dacc)
            a_r6_mag_winner: assert (
               word_mag(fin[w*WORD_W +: WORD_W]) >= word_mag(s1_x[w*WORD_W +: WORD_W]) &&
               word_mag(fin[w*WORD_W +: WORD_W]) >= word_mag(s1_y[w*WORD_W +: WORD_W]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res        <= '0;
         wr_idx     <= '0;
         wr_partner <= 1'b0;
      end else if (take1) begin
         res        <= (op == OP_AVGB) ? avg_b : sat_w;
         wr_partner <= op_to_partner(op);
         wr_idx     <= op_to_partner(op) ? (dst_idx ^ FLIP) : dst_idx;
      end else if (busy) begin
         res        <= fin;
         wr_partner <= s1_dacc;
         wr_idx     <= s1_dacc ? (s1_dst ^ FLIP) : s1_dst;
      end
   end

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!take1 && !busy) |=> $stable(res) && $stable(wr_idx));
endmodule

// File: tb/pk_satalu_tb.sv
`timescale 1ns/1ps
module pk_satalu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [2:0]  dst_idx = 3'd0;
   logic [63:0] opnd_reg = '0, opnd_src = '0, partner_val = '0;
   logic [63:0] res;
   logic [2:0]  wr_idx;
   logic        wr_partner, done;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pk_satalu u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dst_idx(dst_idx),
      .opnd_reg(opnd_reg), .opnd_src(opnd_src), .partner_val(partner_val),
      .res(res), .wr_idx(wr_idx), .wr_partner(wr_partner), .done(done)
   );

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] e_word(input logic [63:0] a, input logic [63:0] b, input int sel);
      logic [63:0] r;
      for (int w = 0; w < 4; w++) begin
         int x, y, s, ma, mb;
         x = int'($signed(a[16*w +: 16]));
         y = int'($signed(b[16*w +: 16]));
         if (sel == 4) begin
            ma = (x < 0) ? -x : x;
            mb = (y < 0) ? -y : y;
            s = (mb > ma) ? y : x;
         end else begin
            s = (sel == 1) ? x - y : x + y;
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
         end
         r[16*w +: 16] = s[15:0];
      end
      return r;
   endfunction

   function automatic logic [63:0] e_byte(input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] p, input int sel);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) begin
         int x, y, z, s;
         x = int'(a[8*k +: 8]);
         y = int'(b[8*k +: 8]);
         z = int'(p[8*k +: 8]);
         if (sel == 2) s = (x + y + 1) / 2;
         else begin
            s = ((x > y) ? x - y : y - x) + z;
            if (s > 255) s = 255;
         end
         r[8*k +: 8] = s[7:0];
      end
      return r;
   endfunction

   task automatic run_op(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] p, input logic [2:0] d, input string req);
      logic [63:0] exp;
      logic        two, part;
      two  = (o == 3'd3) || (o == 3'd4);
      part = (o == 3'd0) || (o == 3'd1) || (o == 3'd3);
      exp  = (o == 3'd2 || o == 3'd3) ? e_byte(a, b, p, int'(o)) : e_word(a, b, int'(o));
      @(negedge clk);
      start = 1'b1; op = o; opnd_reg = a; opnd_src = b; partner_val = p; dst_idx = d;
      @(negedge clk);
      start = 1'b0;
      if (two) begin
         chk(done == 1'b0, {req, " latency 2 first cycle"}, 64'(done), 64'd0);
         @(negedge clk);
      end
      chk(done == 1'b1, {req, " done"}, 64'(done), 64'd1);
      chk(res == exp, {req, " result"}, res, exp);
      chk(wr_partner == part && wr_idx == (part ? (d ^ 3'd1) : d), "R7 index",
          {60'd0, wr_partner, wr_idx}, {60'd0, part, part ? (d ^ 3'd1) : d});
      @(negedge clk);
      chk(done == 1'b0, "R8 single pulse", 64'(done), 64'd0);
      chk(res == exp, "R10 hold", res, exp);
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int vals[9] = '{0, 1, -1, 32767, -32768, 100, -100, 16384, -16385};
      logic [63:0] a, b, p, held;
      repeat (3) @(negedge clk);
      chk(done == 0 && res == 0 && wr_partner == 0 && wr_idx == 0, "R1 reset",
          res, 64'd0);
      rst_n = 1'b1;

      // signed-word sweep over every value pair
      for (int i = 0; i < 9; i++) begin
         for (int j = 0; j < 9; j++) begin
            a = {vals[i][15:0], vals[j][15:0], vals[(i+3)%9][15:0], vals[(j+5)%9][15:0]};
            b = {vals[j][15:0], vals[i][15:0], vals[(j+4)%9][15:0], vals[(i+7)%9][15:0]};
            run_op(3'd0, a, b, 64'd0, 3'((i + j) % 8), "R2 add");
            run_op(3'd1, a, b, 64'd0, 3'(i % 8), "R3 sub");
            run_op(3'd4, a, b, 64'd0, 3'(j % 8), "R6 magnitude");
         end
      end
      // tie and -32768 corner for R6
      run_op(3'd4, 64'h8000_0005_FFFB_7FFF, 64'h7FFF_FFFB_0005_8000, 64'd0, 3'd5, "R6 tie");

      // unsigned-byte sweep
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            for (int k = 0; k < 8; k++) begin
               a[8*k +: 8] = 8'((i * 17 + k * 31) & 255);
               b[8*k +: 8] = 8'((j * 17 + k * 7 + 3) & 255);
               p[8*k +: 8] = 8'((i * j * 5 + k * 40 + 120) & 255);
            end
            run_op(3'd2, a, b, p, 3'((i + 2 * j) % 8), "R4 average");
            run_op(3'd3, a, b, p, 3'((2 * i + j) % 8), "R5 dist-acc");
         end
      end

      // R8: a second start during a two-cycle operation is dropped
      a = 64'h10FF_2000_3344_0080;
      b = 64'h00F0_20FF_4433_8000;
      p = 64'hF0F0_0000_FFFF_1234;
      held = e_byte(a, b, p, 3);
      @(negedge clk);
      start = 1'b1; op = 3'd3; opnd_reg = a; opnd_src = b; partner_val = p; dst_idx = 3'd6;
      @(negedge clk);
      op = 3'd0; opnd_reg = 64'h7FFF_7FFF_7FFF_7FFF; opnd_src = 64'h0001_0001_0001_0001; dst_idx = 3'd2;
      chk(done == 1'b0, "R8 busy no done", 64'(done), 64'd0);
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1 && res == held, "R8 first op wins", res, held);
      chk(wr_idx == 3'd7 && wr_partner, "R8 partner index kept", 64'(wr_idx), 64'd7);
      @(negedge clk);
      chk(done == 1'b0 && res == held, "R8 dropped start", res, held);

      // R9: unused opcodes
      for (int o = 5; o < 8; o++) begin
         @(negedge clk);
         start = 1'b1; op = 3'(o); opnd_reg = 64'h1111; opnd_src = 64'h2222;
         @(negedge clk);
         start = 1'b0;
         chk(done == 1'b0, "R9 no done", 64'(done), 64'd0);
         @(negedge clk);
         chk(done == 1'b0 && res == held, "R9 result unchanged", res, held);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule